// File: doc/BRIEF.md
# Receive-DMA Write Command Selector

This block sits beside the bus master of a receive DMA engine and picks, for every write burst, between a plain memory write (command code 0x7) and a memory write and invalidate (command code 0xF). The invalidate form lets the memory system skip a read-for-ownership, but it may only be used when whole cache lines are written. The block checks that before it issues an invalidate burst, and keeps checking while the burst runs.

Software programs a line-size register that keeps only the two supported sizes. When a request arrives, the block looks at the target dword address, the number of dwords waiting in the receive FIFO, the free space in the destination buffer and two enable bits. It then issues a command, a start address and a length. While the burst runs, the bus state machine reports each data beat and any termination. The block raises a flag when the current line must be the last one, marks the final beat, and re-issues bursts after a retry or a disconnect.

Top module: `mwsel_cmd_select`

## Requirements
- R1: Writing 8 to the line-size register makes it read 0x08 (only bit 3 set) from the next cycle. Writing 16 makes it read 0x10 (only bit 4 set). The register reads 0x00 after reset.
- R2: Writing any other value makes the register read 0x00, and every later request then gets command 0x7 until a legal size is written.
- R3: A request in idle gets command 0xF with length equal to the line size only when all of these hold: the line size is legal, both enables are 1, the low bits of the dword address are zero (3 bits for 8, 4 bits for 16), the FIFO level is at least one line and the buffer space is at least one line. If any of them fails, the request gets command 0x7.
- R4: A 0x7 burst chosen at a request has length min(FIFO level, buffer space, MAX_BURST). If that minimum is zero, nothing is issued and the block stays idle.
- R5: `issue` is high for exactly the cycle after the request cycle. `burst_addr` then equals the requested address.
- R6: During a 0xF burst the block looks ahead to the next whole line. If the enables are set, that line is aligned, and FIFO level and buffer space both cover the rest of the current line plus one more line, the burst continues into the next line. Otherwise `line_stop` is high, and `last_beat` rises on the final beat of the current line.
- R7: Termination code 2'b01 (retry) re-issues, on the next cycle, the same command, start address and length.
- R8: Termination code 2'b10 (disconnect) issues, on the next cycle, command 0x7 starting at the dword after the last transferred one, with length equal to the beats still owed in the interrupted line or burst.
- R9: While a 0xF burst is active, `byte_en` is 4'hF. Otherwise `byte_en` follows `wr_be`.
- R10: A write to the line-size register during a burst changes neither that burst's line length nor its extensions. The next request uses the new size.
- R11: Termination code 2'b11 (done), or a beat taken while `last_beat` is high, returns the block to idle (`busy` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cls_wr | input | 1 | Write strobe for the line-size register |
| cls_wdata | input | 8 | Value written to the line-size register |
| cls_rdata | output | 8 | Read value of the line-size register |
| cmd_inv_en | input | 1 | Invalidate enable from the configuration command register |
| dev_inv_en | input | 1 | Invalidate enable from the device configuration |
| req_valid | input | 1 | Request a burst decision (honoured in idle) |
| req_addr | input | AW | Dword address of the burst start |
| fifo_level | input | FILL_W | Dwords waiting in the receive FIFO, not yet transferred |
| buf_space | input | SPACE_W | Dwords free in the destination buffer, not yet written |
| wr_be | input | 4 | Byte enables used for plain writes |
| beat | input | 1 | One dword transferred this cycle |
| term_valid | input | 1 | A termination status is presented |
| term_code | input | 2 | 01 retry, 10 disconnect, 11 done |
| busy | output | 1 | A burst is in progress |
| issue | output | 1 | One-cycle pulse: start a burst with the outputs below |
| cmd | output | 4 | Bus command, 0x7 or 0xF |
| burst_addr | output | AW | Dword start address of the issued burst |
| burst_len | output | LEN_W | Dwords in the issued burst (one line for 0xF) |
| byte_en | output | 4 | Byte enables for the data beats |
| line_stop | output | 1 | Current invalidate line is the last of the burst |
| last_beat | output | 1 | The next beat completes the burst |

## Verification
The assertions assume that the bus state machine presents termination only while `busy` is high and never in the same cycle as `beat`. They also assume that a retry arrives before any beat of that attempt, and that `req_valid` is raised only in idle. The bench keeps to this: every step moves through one task that drives a single input group per cycle, terminations are sent only after an issue and with `beat` low, and retries come straight after the issue. FIFO level and buffer space are held steady across a look-ahead point unless a step lowers them on purpose.

// File: rtl/mwsel_pkg.sv
package mwsel_pkg;

   localparam logic [3:0] CMD_MEMWR    = 4'h7;
   localparam logic [3:0] CMD_MEMWRINV = 4'hF;

   typedef enum logic [1:0] {
      TERM_NONE  = 2'b00,
      TERM_RETRY = 2'b01,
      TERM_DISC  = 2'b10,
      TERM_DONE  = 2'b11
   } term_e;

   typedef enum logic {
      ST_IDLE,
      ST_BURST
   } st_e;

endpackage

// File: rtl/mwsel_line_reg.sv
module mwsel_line_reg #(
   parameter int REG_W      = 8,
   parameter int LINE_W     = 5,
   parameter int MIN_LOG2   = 3,
   parameter int N_LEGAL    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic [LINE_W-1:0] line,
   output logic              valid
);

   localparam int TOP_LOG2 = MIN_LOG2 + N_LEGAL - 1;
   localparam logic [REG_W-1:0] LEGAL_MASK =
      REG_W'(((1 << N_LEGAL) - 1) << MIN_LOG2);

   if (TOP_LOG2 >= LINE_W) begin : g_bad_line_w
      $error("LINE_W too narrow for largest legal line size");
   end
   if (TOP_LOG2 >= REG_W) begin : g_bad_reg_w
      $error("REG_W too narrow for largest legal line size");
   end

   logic [N_LEGAL-1:0] hit;
   logic [REG_W-1:0]   size_q;

   for (genvar g = 0; g < N_LEGAL; g++) begin : g_legal
      assign hit[g] = (wdata == REG_W'(1 << (MIN_LOG2 + g)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         size_q <= '0;
      end else if (wr) begin
         size_q <= (|hit) ? wdata : '0;
      end
   end

   assign rdata = size_q;
   assign valid = |size_q;
   assign line  = LINE_W'(size_q);

   assert_line_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(size_q) && ((size_q & ~LEGAL_MASK) == '0));

endmodule

// File: rtl/mwsel_qualify.sv
module mwsel_qualify #(
   parameter int AW      = 30,
   parameter int FILL_W  = 8,
   parameter int SPACE_W = 12,
   parameter int LINE_W  = 5,
   parameter int CW      = 14
) (
   input  logic [AW-1:0]      addr,
   input  logic [LINE_W-1:0]  line,
   input  logic [CW-1:0]      need,
   input  logic [FILL_W-1:0]  fifo,
   input  logic [SPACE_W-1:0] space,
   input  logic               gate,
   output logic               ok
);

   if (CW <= FILL_W || CW <= SPACE_W) begin : g_bad_cw
      $error("compare width must exceed the level widths");
   end

   logic [AW-1:0] mask;
   logic          aligned;
   logic          fifo_ok;
   logic          space_ok;

   always_comb begin
      mask     = AW'(line) - AW'(1);
      aligned  = ((addr & mask) == '0);
      fifo_ok  = (CW'(fifo)  >= need);
      space_ok = (CW'(space) >= need);
      ok       = gate && aligned && fifo_ok && space_ok;
   end

endmodule

// File: rtl/mwsel_burst_fsm.sv
module mwsel_burst_fsm
   import mwsel_pkg::*;
#(
   parameter int AW        = 30,
   parameter int FILL_W    = 8,
   parameter int SPACE_W   = 12,
   parameter int LINE_W    = 5,
   parameter int LEN_W     = 8,
   parameter int MAX_BURST = 64,
   parameter int CW        = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [AW-1:0]      req_addr,
   input  logic [FILL_W-1:0]  fifo,
   input  logic [SPACE_W-1:0] space,
   input  logic [LINE_W-1:0]  line_live,
   input  logic               start_inv_ok,
   input  logic               hold_ok,
   input  logic               beat,
   input  logic               term_valid,
   input  logic [1:0]         term_code,
   output logic               busy,
   output logic               issue,
   output logic [3:0]         cmd,
   output logic [AW-1:0]      burst_addr,
   output logic [LEN_W-1:0]   burst_len,
   output logic [AW-1:0]      cur_addr,
   output logic [LEN_W-1:0]   left,
   output logic [LINE_W-1:0]  line_used,
   output logic               line_stop,
   output logic               last_beat
);

   if (MAX_BURST >= (1 << LEN_W) || MAX_BURST < (1 << (LINE_W - 1))) begin : g_bad_max
      $error("MAX_BURST must hold one line and fit in LEN_W");
   end

   st_e              state_q;
   logic             issue_q;
   logic [3:0]       cmd_q;
   logic [AW-1:0]    start_q;
   logic [AW-1:0]    addr_q;
   logic [LEN_W-1:0] left_q;
   logic [LEN_W-1:0] len_q;
   logic [LINE_W-1:0] line_q;
   logic [CW-1:0]    mw_len;
   logic             is_inv;

   always_comb begin
      mw_len = (CW'(fifo) < CW'(space)) ? CW'(fifo) : CW'(space);
      if (mw_len > CW'(MAX_BURST)) begin
         mw_len = CW'(MAX_BURST);
      end
   end

   assign is_inv = (cmd_q == CMD_MEMWRINV);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         issue_q <= 1'b0;
         cmd_q   <= CMD_MEMWR;
         start_q <= '0;
         addr_q  <= '0;
         left_q  <= '0;
         len_q   <= '0;
         line_q  <= '0;
      end else begin
         issue_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (start_inv_ok) begin
                     cmd_q   <= CMD_MEMWRINV;
                     left_q  <= LEN_W'(line_live);
                     len_q   <= LEN_W'(line_live);
                     line_q  <= line_live;
                     start_q <= req_addr;
                     addr_q  <= req_addr;
                     issue_q <= 1'b1;
                     state_q <= ST_BURST;
                  end else if (mw_len != '0) begin
                     cmd_q   <= CMD_MEMWR;
                     left_q  <= LEN_W'(mw_len);
                     len_q   <= LEN_W'(mw_len);
                     line_q  <= line_live;
                     start_q <= req_addr;
                     addr_q  <= req_addr;
                     issue_q <= 1'b1;
                     state_q <= ST_BURST;
                  end
               end
            end
            ST_BURST: begin
               if (term_valid) begin
                  case (term_e'(term_code))
                     TERM_RETRY: begin
                        addr_q  <= start_q;
                        left_q  <= len_q;
                        issue_q <= 1'b1;
                     end
                     TERM_DISC: begin
                        cmd_q   <= CMD_MEMWR;
                        start_q <= addr_q;
                        len_q   <= left_q;
                        issue_q <= 1'b1;
                     end
                     TERM_DONE: begin
                        state_q <= ST_IDLE;
                     end
                     default: ;
                  endcase
               end else if (beat) begin
                  addr_q <= addr_q + AW'(1);
                  if (left_q == LEN_W'(1)) begin
                     if (is_inv && hold_ok) begin
                        left_q <= LEN_W'(line_q);
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end else begin
                     left_q <= left_q - LEN_W'(1);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state_q == ST_BURST);
   assign issue      = issue_q;
   assign cmd        = cmd_q;
   assign burst_addr = start_q;
   assign burst_len  = len_q;
   assign cur_addr   = addr_q;
   assign left       = left_q;
   assign line_used  = line_q;
   assign line_stop  = busy && is_inv && !hold_ok;
   assign last_beat  = busy && (left_q == LEN_W'(1)) && (!is_inv || !hold_ok);

   assert_inv_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_q && is_inv) |-> ((start_q & (AW'(line_q) - AW'(1))) == '0));

   assert_retry_same_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && term_valid && term_code == 2'b01) |=>
         (issue_q && cmd_q == $past(cmd_q) && start_q == $past(start_q)));

   assert_disc_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && term_valid && term_code == 2'b10) |=>
         (issue_q && cmd_q == CMD_MEMWR && start_q == $past(addr_q)));

   assert_end_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && beat && !term_valid && last_beat) |=> !busy);

endmodule

// File: rtl/mwsel_cmd_select.sv
module mwsel_cmd_select
   import mwsel_pkg::*;
#(
   parameter int AW        = 30,
   parameter int FILL_W    = 8,
   parameter int SPACE_W   = 12,
   parameter int LEN_W     = 8,
   parameter int MAX_BURST = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cls_wr,
   input  logic [7:0]         cls_wdata,
   output logic [7:0]         cls_rdata,
   input  logic               cmd_inv_en,
   input  logic               dev_inv_en,
   input  logic               req_valid,
   input  logic [AW-1:0]      req_addr,
   input  logic [FILL_W-1:0]  fifo_level,
   input  logic [SPACE_W-1:0] buf_space,
   input  logic [3:0]         wr_be,
   input  logic               beat,
   input  logic               term_valid,
   input  logic [1:0]         term_code,
   output logic               busy,
   output logic               issue,
   output logic [3:0]         cmd,
   output logic [AW-1:0]      burst_addr,
   output logic [LEN_W-1:0]   burst_len,
   output logic [3:0]         byte_en,
   output logic               line_stop,
   output logic               last_beat
);

   localparam int LINE_W = 5;
   localparam int W_A    = (FILL_W > SPACE_W) ? FILL_W : SPACE_W;
   localparam int W_B    = (W_A > LEN_W + 1) ? W_A : LEN_W + 1;
   localparam int CW     = W_B + 1;

   logic [LINE_W-1:0] line_live;
   logic              line_valid;
   logic [AW-1:0]     cur_addr;
   logic [LEN_W-1:0]  left;
   logic [LINE_W-1:0] line_used;
   logic              start_inv_ok;
   logic              hold_ok;
   logic [CW-1:0]     hold_need;
   logic [AW-1:0]     next_line_addr;

   mwsel_line_reg #(
      .REG_W    (8),
      .LINE_W   (LINE_W),
      .MIN_LOG2 (3),
      .N_LEGAL  (2)
   ) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cls_wr),
      .wdata (cls_wdata),
      .rdata (cls_rdata),
      .line  (line_live),
      .valid (line_valid)
   );

   mwsel_qualify #(
      .AW (AW), .FILL_W (FILL_W), .SPACE_W (SPACE_W), .LINE_W (LINE_W), .CW (CW)
   ) u_start_q (
      .addr  (req_addr),
      .line  (line_live),
      .need  (CW'(line_live)),
      .fifo  (fifo_level),
      .space (buf_space),
      .gate  (line_valid && cmd_inv_en && dev_inv_en),
      .ok    (start_inv_ok)
   );

   assign hold_need      = CW'(left) + CW'(line_used);
   assign next_line_addr = cur_addr + AW'(left);

   mwsel_qualify #(
      .AW (AW), .FILL_W (FILL_W), .SPACE_W (SPACE_W), .LINE_W (LINE_W), .CW (CW)
   ) u_hold_q (
      .addr  (next_line_addr),
      .line  (line_used),
      .need  (hold_need),
      .fifo  (fifo_level),
      .space (buf_space),
      .gate  (cmd_inv_en && dev_inv_en),
      .ok    (hold_ok)
   );

   mwsel_burst_fsm #(
      .AW (AW), .FILL_W (FILL_W), .SPACE_W (SPACE_W), .LINE_W (LINE_W),
      .LEN_W (LEN_W), .MAX_BURST (MAX_BURST), .CW (CW)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_addr     (req_addr),
      .fifo         (fifo_level),
      .space        (buf_space),
      .line_live    (line_live),
      .start_inv_ok (start_inv_ok),
      .hold_ok      (hold_ok),
      .beat         (beat),
      .term_valid   (term_valid),
      .term_code    (term_code),
      .busy         (busy),
      .issue        (issue),
      .cmd          (cmd),
      .burst_addr   (burst_addr),
      .burst_len    (burst_len),
      .cur_addr     (cur_addr),
      .left         (left),
      .line_used    (line_used),
      .line_stop    (line_stop),
      .last_beat    (last_beat)
   );

   assign byte_en = (busy && cmd == CMD_MEMWRINV) ? 4'hF : wr_be;

   assert_inv_len_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && cmd == CMD_MEMWRINV) |-> (burst_len == LEN_W'(8) || burst_len == LEN_W'(16)));

   assert_inv_full_be_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd == CMD_MEMWRINV && beat) |-> (byte_en == 4'hF));

endmodule

// File: tb/test_mwsel_cmd_select.sv
module test_mwsel_cmd_select;

   localparam int PERIOD = 10;
   localparam int AW = 30;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cls_wr = 1'b0;
   logic [7:0] cls_wdata = '0;
   logic [7:0] cls_rdata;
   logic cmd_inv_en = 1'b1;
   logic dev_inv_en = 1'b1;
   logic req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0] fifo_level = '0;
   logic [11:0] buf_space = '0;
   logic [3:0] wr_be = 4'h5;
   logic beat = 1'b0;
   logic term_valid = 1'b0;
   logic [1:0] term_code = 2'b00;
   logic busy, issue, line_stop, last_beat;
   logic [3:0] cmd, byte_en;
   logic [AW-1:0] burst_addr;
   logic [7:0] burst_len;

   int checks = 0;
   int errors = 0;
   int q_cmd[$];
   int q_addr[$];
   int q_len[$];
   string q_tag[$];

   always #(PERIOD/2) clk = ~clk;

   mwsel_cmd_select i_mwsel_cmd_select (
      .clk (clk), .rst_n (rst_n), .cls_wr (cls_wr), .cls_wdata (cls_wdata),
      .cls_rdata (cls_rdata), .cmd_inv_en (cmd_inv_en), .dev_inv_en (dev_inv_en),
      .req_valid (req_valid), .req_addr (req_addr), .fifo_level (fifo_level),
      .buf_space (buf_space), .wr_be (wr_be), .beat (beat), .term_valid (term_valid),
      .term_code (term_code), .busy (busy), .issue (issue), .cmd (cmd),
      .burst_addr (burst_addr), .burst_len (burst_len), .byte_en (byte_en),
      .line_stop (line_stop), .last_beat (last_beat)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic expect_issue(input int c, input int a, input int l, input string tag);
      q_cmd.push_back(c);
      q_addr.push_back(a);
      q_len.push_back(l);
      q_tag.push_back(tag);
   endtask

   // monitor: pops one expected burst per issue pulse
   always @(negedge clk) begin
      if (rst_n && issue) begin
         if (q_cmd.size() == 0) begin
            check(1'b0, "R5 unexpected issue", int'(cmd), 0);
         end else begin
            int c, a, l;
            string t;
            c = q_cmd.pop_front();
            a = q_addr.pop_front();
            l = q_len.pop_front();
            t = q_tag.pop_front();
            check(int'(cmd) == c, {t, " cmd"}, int'(cmd), c);
            check(int'(burst_addr) == a && int'(burst_len) == l,
                  {t, " addr*1000+len"}, int'(burst_addr) * 1000 + int'(burst_len), a * 1000 + l);
         end
      end
   end

   task automatic set_cls(input int v);
      cls_wr = 1'b1;
      cls_wdata = 8'(v);
      @(posedge clk); #1;
      cls_wr = 1'b0;
   endtask

   task automatic request(input int a, input int f, input int b, input bit exp_issue);
      req_addr = AW'(a);
      fifo_level = 8'(f);
      buf_space = 12'(b);
      req_valid = 1'b1;
      @(posedge clk); #1;
      req_valid = 1'b0;
      check(issue == exp_issue, "R5 issue pulse timing", int'(issue), int'(exp_issue));
   endtask

   task automatic beats(input int n);
      beat = 1'b1;
      repeat (n) @(posedge clk);
      #1 beat = 1'b0;
   endtask

   task automatic term(input logic [1:0] code);
      term_valid = 1'b1;
      term_code = code;
      @(posedge clk); #1;
      term_valid = 1'b0;
      term_code = 2'b00;
   endtask

   initial begin
      #(PERIOD * 150000);
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      check(cls_rdata == 8'h00, "R1 reset read", int'(cls_rdata), 0);
      check(busy == 1'b0 && issue == 1'b0, "R11 reset idle", int'(busy), 0);

      // R1 / R2 line-size register
      set_cls(8);
      check(cls_rdata == 8'h08, "R1 write 8", int'(cls_rdata), 8);
      set_cls(16);
      check(cls_rdata == 8'h10, "R1 write 16", int'(cls_rdata), 16);
      set_cls(12);
      check(cls_rdata == 8'h00, "R2 write 12", int'(cls_rdata), 0);
      set_cls(16);
      set_cls(24);
      check(cls_rdata == 8'h00, "R2 write 24", int'(cls_rdata), 0);

      // R2: illegal size forces plain write
      expect_issue(7, 0, 32, "R2");
      request(0, 32, 32, 1'b1);
      check(byte_en == 4'h5, "R9 plain be", int'(byte_en), 5);
      term(2'b11);
      check(busy == 1'b0, "R11 done idle", int'(busy), 0);

      // R3 / R6 invalidate with one extension then stop
      set_cls(8);
      expect_issue(15, 8, 8, "R3");
      request(8, 20, 40, 1'b1);
      check(byte_en == 4'hF, "R9 inv be", int'(byte_en), 15);
      beats(7);
      check(last_beat == 1'b0 && line_stop == 1'b0, "R6 extend ahead", int'(last_beat), 0);
      beats(1);
      fifo_level = 8'd5;
      #1;
      check(line_stop == 1'b1, "R6 stop flag", int'(line_stop), 1);
      beats(7);
      check(last_beat == 1'b1, "R6 line end", int'(last_beat), 1);
      beats(1);
      check(busy == 1'b0, "R11 last beat idle", int'(busy), 0);

      // R3 fallbacks
      expect_issue(7, 4, 20, "R3 misaligned");
      request(4, 20, 40, 1'b1);
      term(2'b11);
      dev_inv_en = 1'b0;
      expect_issue(7, 0, 20, "R3 dev enable off");
      request(0, 20, 40, 1'b1);
      term(2'b11);
      dev_inv_en = 1'b1;
      cmd_inv_en = 1'b0;
      expect_issue(7, 16, 20, "R3 cmd enable off");
      request(16, 20, 40, 1'b1);
      term(2'b11);
      cmd_inv_en = 1'b1;

      // R4 lengths
      expect_issue(7, 0, 7, "R4 fifo short");
      request(0, 7, 40, 1'b1);
      term(2'b11);
      expect_issue(7, 0, 6, "R4 space short");
      request(0, 20, 6, 1'b1);
      term(2'b11);
      request(0, 0, 40, 1'b0);
      check(busy == 1'b0, "R4 empty no burst", int'(busy), 0);
      set_cls(16);
      expect_issue(7, 3, 64, "R4 max clip");
      request(3, 100, 200, 1'b1);
      term(2'b11);

      // R7 retry, R8 disconnect
      expect_issue(15, 32, 16, "R3 line16");
      request(32, 40, 40, 1'b1);
      expect_issue(15, 32, 16, "R7");
      term(2'b01);
      beats(5);
      expect_issue(7, 37, 11, "R8");
      term(2'b10);
      check(byte_en == 4'h5, "R9 after disconnect", int'(byte_en), 5);
      beats(10);
      check(last_beat == 1'b1, "R8 remaining length", int'(last_beat), 1);
      beats(1);
      check(busy == 1'b0, "R11 plain end", int'(busy), 0);

      // R10 size change mid-burst
      set_cls(8);
      expect_issue(15, 0, 8, "R10 start");
      request(0, 40, 40, 1'b1);
      set_cls(16);
      check(cls_rdata == 8'h10, "R1 write in burst", int'(cls_rdata), 16);
      beats(7);
      check(last_beat == 1'b0, "R10 extends by old line", int'(last_beat), 0);
      beats(1);
      fifo_level = 8'd3;
      beats(7);
      check(last_beat == 1'b1, "R10 second line is 8", int'(last_beat), 1);
      beats(1);
      check(busy == 1'b0, "R10 end", int'(busy), 0);
      expect_issue(7, 8, 40, "R10 new size misaligned");
      request(8, 40, 40, 1'b1);
      term(2'b11);
      expect_issue(15, 16, 16, "R10 new size aligned");
      request(16, 40, 40, 1'b1);
      term(2'b11);

      repeat (3) @(posedge clk);
      #1;
      check(q_cmd.size() == 0, "R5 all issues seen", q_cmd.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule